// File: doc/BRIEF.md
# Dual-Style Host Register Port

This block is the slave side of an asynchronous parallel host bus. An external processor uses it to reach a bank of 8-bit registers held elsewhere on the chip. The host presents a 10-bit address, chip-select, two strobe pins and an address-latch pin. Data moves on an 8-bit bus. That bus is modelled as separate input, output and output-enable vectors, and the pad that merges them sits outside the block. The two strobe pins are read in one of two ways. In split-strobe style they are separate read and write strobes. In level style the first pin is a read/write level and the second is a data strobe.

Every host control pin passes through a flop synchronizer into the system clock. The address and data lines travel through a flop pipe of the same depth, so each sample lines up with the control edge that uses it. On the register side the block produces a write request and a read request. The write request is a one-cycle valid with address and data. The read request is a one-cycle pulse, and the bank answers it with data on the same cycle. Neither interface has a ready signal: the register bank must accept every request on the cycle it is shown, so no back-pressure exists. The host strobe timing bounds the request rate to one per strobe.

The address-latch pin selects the addressing scheme by how it is used. Held high, it passes the address pins straight through. Pulsed, its falling edge captures the low address byte from the data lines.

Top module: `host_bus_port`

## Requirements
- R1: With `style_sel` = 0, a read is active while `bus_cs_n` and `bus_sa_n` are both low, and a write is active while `bus_cs_n` and `bus_sb_n` are both low.
- R2: With `style_sel` = 1, `bus_sa_n` is a read/write level (1 = read, 0 = write) and `bus_sb_n` is an active-low data strobe. A read needs `bus_cs_n` = 0, `bus_sa_n` = 1 and `bus_sb_n` = 0. A write needs `bus_cs_n` = 0, `bus_sa_n` = 0 and `bus_sb_n` = 0.
- R3: `bus_data_oe` is high only while the read condition of the latched style holds on the raw pins, and never while `bus_cs_n` is high.
- R4: Each write strobe yields exactly one `wr_valid` cycle. It is issued after the strobe is released and carries the address and data sampled in the last cycle the strobe was seen active.
- R5: Read data is taken from `rd_data` in the cycle the read is first detected. `bus_data_o` then holds that value, unchanged, for as long as the bus is driven.
- R6: When `bus_ale` is pulsed, its falling edge captures address bits [7:0] from `bus_data_i`, and bits [9:8] come from `bus_addr[9:8]`.
- R7: While `bus_ale` is high, the address used is `bus_addr` as presented.
- R8: An address at or above `REG_COUNT` (48 by default) reads as zero, whatever `rd_data` holds, and produces no `wr_valid`.
- R9: `style_sel` is adopted only while no access is active. A change during an access does not disturb that access.
- R10: Each detected read raises `rd_req` for exactly one cycle, with `rd_addr` giving the accessed address.
- R11: After reset, `bus_data_oe`, `wr_valid` and `rd_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| style_sel | input | 1 | Strobe style: 0 split strobes, 1 level plus data strobe |
| bus_cs_n | input | 1 | Host chip-select, active low |
| bus_sa_n | input | 1 | Read strobe (style 0) or read/write level (style 1) |
| bus_sb_n | input | 1 | Write strobe (style 0) or data strobe (style 1) |
| bus_ale | input | 1 | Address latch; tie high for direct addressing |
| bus_addr | input | 10 | Host address |
| bus_data_i | input | 8 | Data lines seen by the block |
| bus_data_o | output | 8 | Read data driven to the host |
| bus_data_oe | output | 1 | Pad output enable for the data lines |
| wr_valid | output | 1 | One-cycle register write request |
| wr_addr | output | 10 | Write address |
| wr_data | output | 8 | Write data |
| rd_req | output | 1 | One-cycle register read request |
| rd_addr | output | 10 | Read address |
| rd_data | input | 8 | Register bank data for `rd_addr` |

## Verification
The assertions watch the properties that hold on every cycle. A write request and a read request each last a single cycle. No write request ever carries an unmapped address. The output enable never rises without chip-select. The driven read byte does not move while the bus stays driven. Only the bench scenarios can show the rest: the decode of both strobe styles, latching of the multiplexed address, masking of unmapped reads, and a style change in the middle of an access being ignored. Each of these needs a sequence of host cycles and a register model behind the port.

// File: rtl/host_bus_pkg.sv
package host_bus_pkg;

  typedef enum logic {
    STYLE_SPLIT = 1'b0,
    STYLE_LEVEL = 1'b1
  } strobe_style_e;

  typedef struct packed {
    logic rd;
    logic wr;
  } bus_req_t;

  // Turn raw or synchronized pin levels into read/write activity.
  function automatic bus_req_t decode_req(strobe_style_e style, logic cs_n,
                                          logic sa_n, logic sb_n);
    bus_req_t r;
    if (style == STYLE_SPLIT) begin
      r.rd = !cs_n && !sa_n;
      r.wr = !cs_n && !sb_n;
    end else begin
      r.rd = !cs_n && sa_n && !sb_n;
      r.wr = !cs_n && !sa_n && !sb_n;
    end
    return r;
  endfunction

endpackage

// File: rtl/host_bus_sync.sv
module host_bus_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/host_bus_strobe.sv
module host_bus_strobe
  import host_bus_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic style_in,
  input  logic cs_n,
  input  logic sa_n,
  input  logic sb_n,
  input  logic ale,
  output logic style_q,
  output logic rd_rise,
  output logic wr_fall,
  output logic ale_fall
);

  bus_req_t now_req;
  logic     rd_prev, wr_prev, ale_prev;
  logic     idle;

  always_comb now_req = decode_req(strobe_style_e'(style_q), cs_n, sa_n, sb_n);

  assign idle     = !now_req.rd && !now_req.wr && !rd_prev && !wr_prev;
  assign rd_rise  = now_req.rd && !rd_prev;
  assign wr_fall  = wr_prev && !now_req.wr;
  assign ale_fall = ale_prev && !ale;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      style_q  <= 1'b0;
      rd_prev  <= 1'b0;
      wr_prev  <= 1'b0;
      ale_prev <= 1'b1;
    end else begin
      rd_prev  <= now_req.rd;
      wr_prev  <= now_req.wr;
      ale_prev <= ale;
      if (idle) style_q <= style_in;
    end
  end

endmodule

// File: rtl/host_bus_port.sv
module host_bus_port
  import host_bus_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 8,
  parameter int MUX_W       = 8,
  parameter int REG_COUNT   = 48,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              style_sel,
  input  logic              bus_cs_n,
  input  logic              bus_sa_n,
  input  logic              bus_sb_n,
  input  logic              bus_ale,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_data_oe,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data
);

  localparam int CTRL_W = 4;
  localparam int PIPE_W = ADDR_W + DATA_W;
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(REG_COUNT);

  logic [CTRL_W-1:0] ctrl_s;
  logic [PIPE_W-1:0] pipe_s;
  logic [ADDR_W-1:0] addr_s, eff_addr, eff_q;
  logic [DATA_W-1:0] data_s, data_q, rd_hold;
  logic [MUX_W-1:0]  alat;
  logic              style_q, rd_rise, wr_fall, ale_fall;
  bus_req_t          raw_req;

  host_bus_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL(4'b1111)) u_ctrl_sync (
    .clk(clk), .rst_n(rst_n),
    .d({bus_cs_n, bus_sa_n, bus_sb_n, bus_ale}),
    .q(ctrl_s)
  );

  host_bus_sync #(.W(PIPE_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pipe (
    .clk(clk), .rst_n(rst_n),
    .d({bus_addr, bus_data_i}),
    .q(pipe_s)
  );

  assign {addr_s, data_s} = pipe_s;

  host_bus_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .style_in(style_sel),
    .cs_n(ctrl_s[3]), .sa_n(ctrl_s[2]), .sb_n(ctrl_s[1]), .ale(ctrl_s[0]),
    .style_q(style_q), .rd_rise(rd_rise), .wr_fall(wr_fall), .ale_fall(ale_fall)
  );

  // Direct address while latch pin is high, else latched low byte.
  assign eff_addr = ctrl_s[0] ? addr_s : {addr_s[ADDR_W-1:MUX_W], alat};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_q   <= '0;
      data_q  <= '0;
      alat    <= '0;
      rd_hold <= '0;
    end else begin
      eff_q  <= eff_addr;
      data_q <= data_s;
      if (ale_fall) alat <= data_q[MUX_W-1:0];
      if (rd_rise) rd_hold <= ({1'b0, eff_addr} < LIMIT) ? rd_data : '0;
    end
  end

  assign wr_valid = wr_fall && ({1'b0, eff_q} < LIMIT);
  assign wr_addr  = eff_q;
  assign wr_data  = data_q;
  assign rd_req   = rd_rise;
  assign rd_addr  = eff_addr;

  always_comb raw_req = decode_req(strobe_style_e'(style_q), bus_cs_n, bus_sa_n, bus_sb_n);

  assign bus_data_oe = raw_req.rd;
  assign bus_data_o  = rd_hold;

endmodule

// File: rtl/host_bus_port_checker.sv
module host_bus_port_checker #(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 8,
  parameter int REG_COUNT = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_cs_n,
  input logic              bus_data_oe,
  input logic [DATA_W-1:0] bus_data_o,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              rd_req
);

  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(REG_COUNT);

  a_r4_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  a_r8_mapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ({1'b0, wr_addr} < LIMIT));

  a_r3_oe_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    bus_data_oe |-> !bus_cs_n);

  a_r5_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_data_oe && $past(bus_data_oe) && !$past(rd_req) && !$past(rd_req, 2))
      |-> $stable(bus_data_o));

  a_r10_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

endmodule

bind host_bus_port host_bus_port_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_COUNT(REG_COUNT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_data_oe(bus_data_oe),
  .bus_data_o(bus_data_o), .wr_valid(wr_valid), .wr_addr(wr_addr), .rd_req(rd_req)
);

// File: tb/host_bus_port_bench.sv
`timescale 1ns/1ps
module host_bus_port_bench;

  localparam int REGS = 48;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       style_sel = 1'b0;
  logic       bus_cs_n = 1'b1, bus_sa_n = 1'b1, bus_sb_n = 1'b1, bus_ale = 1'b1;
  logic [9:0] bus_addr = '0;
  logic [7:0] bus_data_i = '0;
  logic [7:0] bus_data_o, wr_data, rd_data;
  logic       bus_data_oe, wr_valid, rd_req;
  logic [9:0] wr_addr, rd_addr;

  int checks = 0;
  int errors = 0;
  logic [7:0]  bank [1024];
  logic [17:0] wr_q [$];
  logic [9:0]  rd_q [$];

  always #2.5 clk = ~clk;

  host_bus_port u_host_bus_port (
    .clk(clk), .rst_n(rst_n), .style_sel(style_sel),
    .bus_cs_n(bus_cs_n), .bus_sa_n(bus_sa_n), .bus_sb_n(bus_sb_n), .bus_ale(bus_ale),
    .bus_addr(bus_addr), .bus_data_i(bus_data_i),
    .bus_data_o(bus_data_o), .bus_data_oe(bus_data_oe),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  assign rd_data = bank[rd_addr];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected write/read requests (R4, R8, R10).
  always @(negedge clk) begin
    if (rst_n && wr_valid) begin
      if (wr_q.size() == 0) check("R4/R8 unexpected write", {22'd0, wr_addr}, 32'hFFFF);
      else check("R4 write request", {14'd0, wr_addr, wr_data}, {14'd0, wr_q.pop_front()});
      bank[wr_addr] = wr_data;
    end
    if (rst_n && rd_req) begin
      if (rd_q.size() == 0) check("R10 unexpected read", {22'd0, rd_addr}, 32'hFFFF);
      else check("R10 read address", {22'd0, rd_addr}, {22'd0, rd_q.pop_front()});
    end
  end

  task automatic put_addr(bit mux, logic [9:0] a);
    if (mux) begin
      bus_addr   = {a[9:8], 8'h3C};
      bus_data_i = a[7:0];
      bus_ale    = 1'b1;
      repeat (2) @(negedge clk);
      bus_ale = 1'b0;
      repeat (3) @(negedge clk);
    end else begin
      bus_ale  = 1'b1;
      bus_addr = a;
    end
  endtask

  // One host access; for reads the bus value is checked mid-strobe.
  task automatic access(bit moto, bit mux, bit is_wr, logic [9:0] a, logic [7:0] d, string req);
    @(negedge clk);
    put_addr(mux, a);
    if (moto) bus_sa_n = !is_wr;
    bus_cs_n = 1'b0;
    repeat (2) @(negedge clk);
    if (is_wr) begin
      bus_data_i = d;
      if (({22'd0, a}) < REGS) wr_q.push_back({a, d});
      if (moto) bus_sb_n = 1'b0; else bus_sb_n = 1'b0;
    end else begin
      rd_q.push_back(a);
      if (moto) bus_sb_n = 1'b0; else bus_sa_n = 1'b0;
    end
    repeat (8) @(negedge clk);
    if (!is_wr) begin
      check({req, " oe"}, {31'd0, bus_data_oe}, 32'd1);
      check({req, " data"}, {24'd0, bus_data_o}, (({22'd0, a}) < REGS) ? {24'd0, bank[a]} : 32'd0);
    end
    bus_sb_n = 1'b1;
    bus_sa_n = 1'b1;
    repeat (2) @(negedge clk);
    bus_cs_n = 1'b1;
    bus_data_i = 8'hE7;
    bus_ale = 1'b1;
    repeat (14) @(negedge clk);
  endtask

  initial begin
    #50000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) bank[i] = 8'((i * 7 + 3) | 1);
    repeat (4) @(negedge clk);
    check("R11 oe after reset", {31'd0, bus_data_oe}, 32'd0);
    check("R11 wr_valid after reset", {31'd0, wr_valid}, 32'd0);
    check("R11 rd_req after reset", {31'd0, rd_req}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Split-strobe style, direct address (R1, R7)
    access(0, 0, 1, 10'd5, 8'h5A, "R1 split write");
    access(0, 0, 0, 10'd5, 8'h00, "R1 R7 split read");
    access(0, 0, 0, 10'd47, 8'h00, "R7 last mapped read");
    // Unmapped (R8)
    access(0, 0, 1, 10'd48, 8'h77, "R8 unmapped write");
    access(0, 0, 0, 10'h3F0, 8'h00, "R8 unmapped read");
    // Read/write level style (R2)
    style_sel = 1'b1;
    repeat (4) @(negedge clk);
    access(1, 0, 1, 10'd12, 8'hC3, "R2 level write");
    access(1, 0, 0, 10'd12, 8'h00, "R2 level read");
    // level style: data strobe low with cs high must not drive (R3)
    bus_sa_n = 1'b1; bus_sb_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R3 no drive without cs", {31'd0, bus_data_oe}, 32'd0);
    bus_sb_n = 1'b1;
    repeat (4) @(negedge clk);
    // Multiplexed address (R6)
    access(1, 1, 1, 10'd33, 8'h9E, "R6 muxed write");
    access(1, 1, 0, 10'd33, 8'h00, "R6 muxed read");
    access(1, 1, 0, 10'h2A1, 8'h00, "R6 R8 muxed unmapped read");
    style_sel = 1'b0;
    repeat (4) @(negedge clk);
    access(0, 1, 1, 10'd40, 8'h21, "R6 split muxed write");
    access(0, 1, 0, 10'd40, 8'h00, "R6 split muxed read");
    // split style: read strobe with cs high (R1, R3)
    bus_sa_n = 1'b0;
    repeat (6) @(negedge clk);
    check("R1 R3 read strobe without cs", {31'd0, bus_data_oe}, 32'd0);
    bus_sa_n = 1'b1;
    repeat (4) @(negedge clk);

    // Style change during an access is ignored (R9, R5)
    @(negedge clk);
    bus_addr = 10'd5; bus_cs_n = 1'b0;
    rd_q.push_back(10'd5);
    repeat (2) @(negedge clk);
    bus_sa_n = 1'b0;
    repeat (8) @(negedge clk);
    style_sel = 1'b1;
    repeat (6) @(negedge clk);
    check("R9 oe kept after style change", {31'd0, bus_data_oe}, 32'd1);
    check("R5 R9 data held", {24'd0, bus_data_o}, {24'd0, bank[5]});
    bus_sa_n = 1'b1;
    repeat (2) @(negedge clk);
    bus_cs_n = 1'b1;
    repeat (8) @(negedge clk);
    check("R3 released after read", {31'd0, bus_data_oe}, 32'd0);
    access(1, 0, 0, 10'd12, 8'h00, "R9 level style adopted when idle");

    repeat (10) @(negedge clk);
    check("R4 all writes seen", wr_q.size(), 32'd0);
    check("R10 all reads seen", rd_q.size(), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule